// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple word-wide register bus. A 16-bit down-counter is decremented by a slow tick. The tick comes from the system clock through two stages: an 8-bit programmable prescaler (divide by P+1), then a selectable fixed divider (divide by 16, 32, 64 or 128). Software keeps the watchdog alive by writing a fresh value straight into the counter. If software fails to do so, the counter runs out. The block then reloads the counter from a reload register and signals the event.

The event can raise a sticky interrupt, a one-clock reset request, both, or neither, as software chooses. The interrupt is cleared by writing any value to a dedicated write-only slot. A debug-acknowledge input can suppress both outputs while a mask bit in the control register is set, so a halted processor is not reset.

Top module: `pscl_wdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the control word reads 0, and the reload and counter slots both read 0x8000. irq and rst_req are low.
- R2: The slot is selected by byte address bits [3:2]: 0 is control, 1 is reload, 2 is counter, 3 is interrupt clear. The control word keeps only bits 0, 2, 3, 4, 5, 8 to 15 and 16, so writing all ones reads back 0x0001FF3D. The clear slot reads as 0. The read data is combinational on the address.
- R3: While the run bit (control bit 5) is set, one tick occurs every (P+1)*(16<<S) clocks. P is control bits [15:8] and S is control bits [4:3]. The first tick comes on the (P+1)*(16<<S)-th rising edge after the edge that wrote the run bit.
- R4: The counter changes only on a tick or on a counter write. While run is clear, the prescaler restarts from zero and the counter holds its value.
- R5: A write to the counter slot loads bits [15:0] at that edge, and this overrides a tick in the same cycle. Reads of the counter slot return the live count. Kicking more often than the counter can run out prevents any expiry.
- R6: On a tick with the counter at 1 (or 0), the counter is loaded from the reload register instead of decrementing. This event is an expiry.
- R7: On an expiry with the interrupt-enable bit (control bit 2) set, a pending flag is set from the next cycle and drives irq high. The flag stays set, even with the timer stopped, until any value is written to the clear slot. If an expiry and a clear happen in the same cycle, the expiry wins.
- R8: On an expiry with the reset-enable bit (control bit 0) set, rst_req is high for exactly one clock, in the cycle after the expiry.
- R9: While control bit 16 and dbg_ack are both high, irq and rst_req are held low in that same cycle. The pending flag is still recorded and shows on irq once dbg_ack falls.
- R10: With run set but both interrupt-enable and reset-enable clear, an expiry still reloads the counter but raises neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed slot |
| dbg_ack | input | 1 | Debug-acknowledge from the processor |
| irq | output | 1 | Level interrupt, high while pending and not masked |
| rst_req | output | 1 | One-clock reset request pulse |

## Verification
Register writes take effect at the sampling edge, so read data and the control effects are due in the cycle after. The counter moves on the (P+1)·D-th enabled edge. irq and rst_req rise in the cycle after the reloading tick, and the debug mask acts in the same cycle as dbg_ack. The bench drives inputs one nanosecond after each rising edge and compares against its reference model at the falling edge, once the edge in question has been counted. The per-cycle compare covers both outputs and every read. Hand-computed checks at exact edge counts pin the tick period, the reload value, the clear and the mask.

// File: rtl/pscl_wdog_pkg.sv
// Shared constants and types of the prescaled watchdog timer.
// Assumes a 32-bit register bus and the control field layout in the brief.
package pscl_wdog_pkg;

    localparam int PRE_W    = 8;   // programmable prescaler width
    localparam int SEL_W    = 2;   // fixed divider select width
    localparam int CTRL_W   = 17;  // used width of the control word
    localparam int SLOT_LSB = 2;   // word-aligned slot decode

    // control field positions (decoded by software drivers)
    localparam int B_RSTEN  = 0;
    localparam int B_IRQEN  = 2;
    localparam int B_SEL    = 3;
    localparam int B_RUN    = 5;
    localparam int B_PRE    = 8;
    localparam int B_DBGMSK = 16;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_COUNT  = 2'd2,
        SLOT_ACK    = 2'd3
    } slot_e;

    typedef struct packed {
        logic             dbg_mask;
        logic [PRE_W-1:0] pre;
        logic             run;
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    // turn a bus word into control fields
    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.rst_en   = w[B_RSTEN];
        c.irq_en   = w[B_IRQEN];
        c.div_sel  = w[B_SEL +: SEL_W];
        c.run      = w[B_RUN];
        c.pre      = w[B_PRE +: PRE_W];
        c.dbg_mask = w[B_DBGMSK];
        return c;
    endfunction

    // turn control fields back into a bus word
    function automatic logic [CTRL_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w                   = '0;
        w[B_RSTEN]          = c.rst_en;
        w[B_IRQEN]          = c.irq_en;
        w[B_SEL +: SEL_W]   = c.div_sel;
        w[B_RUN]            = c.run;
        w[B_PRE +: PRE_W]   = c.pre;
        w[B_DBGMSK]         = c.dbg_mask;
        return w;
    endfunction

endpackage

// File: rtl/pscl_wdog_regs.sv
// Register file: control and reload registers, write strobes for the
// counter and clear slots, and the combinational read mux.
// Assumes DATA_W >= CTRL_W and DATA_W >= CNT_W.
module pscl_wdog_regs
    import pscl_wdog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_count,
    output logic              wr_ack
);

    logic wdata_unused;
    assign wdata_unused = ^wdata[DATA_W-1:CTRL_W];

    // write strobes for slots that live in other modules
    always_comb begin
        wr_count = wr_en && (slot == SLOT_COUNT);
        wr_ack   = wr_en && (slot == SLOT_ACK);
    end

    // control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && slot == SLOT_CTRL) begin
            ctrl <= ctrl_from_word(wdata[CTRL_W-1:0]);
        end
    end

    // reload register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= CNT_W'(RESET_VAL);
        end else if (wr_en && slot == SLOT_RELOAD) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    // read mux; the clear slot has no readable content
    always_comb begin
        unique case (slot)
            SLOT_CTRL:   rdata = DATA_W'(ctrl_to_word(ctrl));
            SLOT_RELOAD: rdata = DATA_W'(reload);
            SLOT_COUNT:  rdata = DATA_W'(count);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/pscl_wdog_tickgen.sv
// Two-stage clock-enable generator: an (P+1) prescaler followed by a
// 2^(BASE_LOG2+sel) divider. Emits a one-cycle tick when both wrap.
// Assumes the divider select is not changed while run is set.
module pscl_wdog_tickgen
    import pscl_wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    localparam int NSEL = 1 << SEL_W;
    localparam int S2_W = BASE_LOG2 + NSEL - 1;

    logic [PRE_W-1:0] s1_q;
    logic [S2_W-1:0]  s2_q;
    logic [S2_W-1:0]  last_tbl [NSEL];
    logic [S2_W-1:0]  s2_last;
    logic             s1_wrap;

    // terminal count for each fixed divider setting
    for (genvar g = 0; g < NSEL; g++) begin : g_last
        assign last_tbl[g] = S2_W'((1 << (BASE_LOG2 + g)) - 1);
    end

    // wrap detection and tick
    always_comb begin
        s2_last = last_tbl[div_sel];
        s1_wrap = (s1_q == pre);
        tick    = run && s1_wrap && (s2_q == s2_last);
    end

    // prescaler stages advance only while running, restart otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (s1_wrap) begin
            s1_q <= '0;
            s2_q <= (s2_q == s2_last) ? '0 : s2_q + 1'b1;
        end else begin
            s1_q <= s1_q + 1'b1;
        end
    end

    // ticks are always separated by at least one idle cycle
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pscl_wdog_counter.sv
// Down-counter with software load and auto-reload on expiry.
// Assumes ticks are single-cycle; a load write overrides a tick.
module pscl_wdog_counter #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);

    // expiry when a tick finds the counter at its last step
    always_comb begin
        expire = tick && !wr_count && (count_q <= CNT_W'(1));
    end

    // counter load, reload and decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_VAL);
        end else if (wr_count) begin
            count_q <= wdata;
        end else if (expire) begin
            count_q <= reload;
        end else if (tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_count) |=> $stable(count_q));

    p_kick_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count_q == $past(wdata)));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count_q == $past(reload)));

endmodule

// File: rtl/pscl_wdog_alarm.sv
// Expiry outputs: sticky interrupt pending flag, one-clock reset pulse,
// and the debug mask on both outputs.
// Assumes expiries are at least two cycles apart.
module pscl_wdog_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic rst_en,
    input  logic wr_ack,
    input  logic dbg_mask,
    input  logic dbg_ack,
    output logic irq,
    output logic rst_req
);

    logic pend_q;
    logic rst_q;
    logic quiet;

    // pending flag: expiry sets, clear write resets, expiry wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (expire && irq_en) begin
            pend_q <= 1'b1;
        end else if (wr_ack) begin
            pend_q <= 1'b0;
        end
    end

    // reset request registered for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= expire && rst_en;
        end
    end

    // debug mask gates both outputs
    always_comb begin
        quiet   = dbg_mask && dbg_ack;
        irq     = pend_q && !quiet;
        rst_req = rst_q && !quiet;
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wr_ack) |=> pend_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !(expire && irq_en)) |=> !pend_q);

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);

endmodule

// File: rtl/pscl_wdog.sv
// Prescaled watchdog timer top: register file, tick generator,
// down-counter and expiry outputs.
// Assumes a byte-addressed bus with word slots at bits [3:2].
module pscl_wdog
    import pscl_wdog_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 4,
    parameter int RESET_VAL = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_ack,
    output logic              irq,
    output logic              rst_req
);

    ctrl_t            ctrl;
    slot_e            slot;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             wr_en;
    logic             wr_count;
    logic             wr_ack;
    logic             tick;
    logic             expire;
    logic             addr_unused;

    // slot decode and write strobe
    always_comb begin
        slot  = slot_e'(bus_addr[SLOT_LSB +: 2]);
        wr_en = bus_sel && bus_wr;
    end

    assign addr_unused = ^{bus_addr[SLOT_LSB-1:0], bus_addr[ADDR_W-1:SLOT_LSB]};

    pscl_wdog_regs #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .RESET_VAL (RESET_VAL)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .slot     (slot),
        .wdata    (bus_wdata),
        .count    (count),
        .ctrl     (ctrl),
        .reload   (reload),
        .rdata    (bus_rdata),
        .wr_count (wr_count),
        .wr_ack   (wr_ack)
    );

    pscl_wdog_tickgen #(
        .BASE_LOG2 (BASE_LOG2)
    ) i_tickgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .pre     (ctrl.pre),
        .div_sel (ctrl.div_sel),
        .tick    (tick)
    );

    pscl_wdog_counter #(
        .CNT_W     (CNT_W),
        .RESET_VAL (RESET_VAL)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_count (wr_count),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .reload   (reload),
        .count_q  (count),
        .expire   (expire)
    );

    pscl_wdog_alarm i_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .irq_en   (ctrl.irq_en),
        .rst_en   (ctrl.rst_en),
        .wr_ack   (wr_ack),
        .dbg_mask (ctrl.dbg_mask),
        .dbg_ack  (dbg_ack),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    // stopped timer never moves the counter between writes
    p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !wr_count) |=> $stable(count));

endmodule

// File: tb/test_pscl_wdog.sv
// Bench: behavioural reference model compared every clock, plus
// hand-computed checks at exact edge counts.
module test_pscl_wdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        dbg_ack = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    always #4 clk = ~clk;

    pscl_wdog i_pscl_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_ack   (dbg_ack),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rst_seen = 0;
    bit done = 0;

    // reference model state
    int m_ctrl, m_reload, m_cnt, m_phase;
    bit m_pend, m_rstq;

    function automatic int period_of(input int c);
        return (((c >> 8) & 255) + 1) * (16 << ((c >> 3) & 3));
    endfunction

    function automatic int model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_ctrl;
            2'd1: return m_reload;
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // model update on each rising edge, from inputs held since last edge
    always @(posedge clk) begin
        bit tick, ex, w;
        if (!rst_n) begin
            m_ctrl = 0; m_reload = 'h8000; m_cnt = 'h8000;
            m_phase = 0; m_pend = 0; m_rstq = 0;
        end else begin
            w = bus_sel && bus_wr;
            tick = 0;
            ex = 0;
            if (m_ctrl[5]) begin
                m_phase++;
                if (m_phase == period_of(m_ctrl)) begin
                    m_phase = 0;
                    tick = 1;
                end
            end else begin
                m_phase = 0;
            end
            if (w && bus_addr[3:2] == 2'd2) m_cnt = int'(bus_wdata & 32'hFFFF);
            else if (tick) begin
                if (m_cnt <= 1) begin m_cnt = m_reload; ex = 1; end
                else m_cnt--;
            end
            m_rstq = ex && m_ctrl[0];
            if (ex && m_ctrl[2]) m_pend = 1;
            else if (w && bus_addr[3:2] == 2'd3) m_pend = 0;
            if (w && bus_addr[3:2] == 2'd0) m_ctrl = int'(bus_wdata & 32'h0001FF3D);
            if (w && bus_addr[3:2] == 2'd1) m_reload = int'(bus_wdata & 32'hFFFF);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle compare of outputs and any read in progress
    always @(negedge clk) begin
        bit quiet;
        if (rst_n && !done) begin
            quiet = m_ctrl[16] && dbg_ack;
            chk("R7/R9 irq", {31'd0, irq}, {31'd0, m_pend && !quiet});
            chk("R8/R9 rst_req", {31'd0, rst_req}, {31'd0, m_rstq && !quiet});
            if (bus_sel && !bus_wr)
                chk("R2/R5 read", bus_rdata, model_read(bus_addr));
            if (rst_req) rst_seen++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // watchdog on the run itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [31:0] v, held;
        int seen0;
        idle(3); #1;
        rst_n = 1;

        // R1 reset state
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h4, v); chk("R1 reload", v, 32'h8000);
        rd(4'h8, v); chk("R1 count", v, 32'h8000);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 field mask and clear slot read
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R2 ctrl mask", v, 32'h0001_FF3D);
        rd(4'hC, v); chk("R2 clear slot", v, 32'h0);
        wr(4'h0, 32'h0);

        // R3, R6, R7: period 16, reload 3, interrupt only
        wr(4'h4, 32'd3);
        wr(4'h8, 32'd3);
        wr(4'h0, 32'h0000_0024);
        idle(16);
        rd(4'h8, v); chk("R3 first tick", v, 32'd2);
        idle(40);
        @(negedge clk); chk("R7 irq set", {31'd0, irq}, 32'd1);
        rd(4'h8, v); chk("R6 reloaded", v, 32'd3);
        wr(4'h0, 32'h0);
        @(negedge clk); chk("R7 sticky when stopped", {31'd0, irq}, 32'd1);
        wr(4'hC, 32'hDEAD_BEEF);
        @(negedge clk); chk("R7 cleared", {31'd0, irq}, 32'd0);

        // R3, R8: P=1, divide by 32, reset only
        seen0 = rst_seen;
        wr(4'h4, 32'd2);
        wr(4'h8, 32'd2);
        wr(4'h0, 32'h0000_0129);
        idle(64);
        rd(4'h8, v); chk("R3 prescaled tick", v, 32'd1);
        idle(80);
        chk("R8 one pulse", rst_seen - seen0, 32'd1);
        chk("R8 no irq", {31'd0, irq}, 32'd0);
        wr(4'h0, 32'h0);

        // R9 debug mask
        seen0 = rst_seen;
        wr(4'h4, 32'd1);
        wr(4'h8, 32'd1);
        @(posedge clk); #1; dbg_ack = 1;
        wr(4'h0, 32'h0001_0025);
        idle(30);
        @(negedge clk); chk("R9 irq masked", {31'd0, irq}, 32'd0);
        chk("R9 rst masked", rst_seen - seen0, 32'd0);
        @(posedge clk); #1; dbg_ack = 0;
        @(negedge clk); chk("R9 irq after unmask", {31'd0, irq}, 32'd1);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);

        // R4 hold while stopped
        wr(4'h4, 32'd5);
        wr(4'h8, 32'd5);
        wr(4'h0, 32'h0000_0020);
        idle(40);
        wr(4'h0, 32'h0);
        rd(4'h8, held);
        idle(100);
        rd(4'h8, v); chk("R4 hold", v, held);

        // R5 kicks keep it from expiring
        wr(4'h4, 32'd4);
        wr(4'h8, 32'd4);
        wr(4'h0, 32'h0000_0024);
        for (int k = 0; k < 6; k++) begin
            idle(40);
            wr(4'h8, 32'd4);
        end
        @(negedge clk); chk("R5 no expiry", {31'd0, irq}, 32'd0);
        wr(4'h0, 32'h0);

        // R10 silent expiry
        seen0 = rst_seen;
        wr(4'h4, 32'd2);
        wr(4'h8, 32'd1);
        wr(4'h0, 32'h0000_0020);
        idle(20);
        rd(4'h8, v); chk("R10 reload", v, 32'd2);
        chk("R10 no irq", {31'd0, irq}, 32'd0);
        chk("R10 no reset", rst_seen - seen0, 32'd0);
        wr(4'h0, 32'h0);

        idle(4);
        done = 1;
        summary();
        $finish;
    end

endmodule